// File: doc/BRIEF.md
# Frame-Paced Heartbeat Generator

This block drives a slow square wave onto an open-drain status pin so that a host controller can see that the audio processor is alive. It does not time itself from the system clock. Instead it counts audio sample frames, which arrive as a one-cycle strobe produced on each LR clock edge of the serial audio port. As a result, the heartbeat stops whenever the audio stream stops. A host that sees no pulses, or pulses with the wrong period, treats the processor as faulty, resets it and sets it up again.

A two-bit rate selection picks how many frames make up one level of the wave. The default counts are chosen so that each level lasts about 100 ms at the selected sample rate. Toggling is held off while the run-enable input is low, for example while the processor waits for its start command. The output is a drive-low enable. When it is 1 the pad pulls the line low. When it is 0 the line is released to its pull-up.

Top module: `frame_heartbeat`

## Requirements
- R1: A synchronous active-low reset releases the pin (hb_pull_low = 0) and clears the frame count, so a full phase of frames is needed before the first toggle after reset.
- R2: While run_en is 1, every accepted frame strobe advances the frame count. The strobe that completes a phase of N frames inverts hb_pull_low in the same clock edge that samples it. The first toggle after reset asserts the drive-low enable.
- R3: The phase length N comes from rate_sel: 0 selects RATE0_FRAMES (default 4800, 48 kHz), 1 selects RATE1_FRAMES (default 4410, 44.1 kHz), 2 selects RATE2_FRAMES (default 3200, 32 kHz) and 3 selects RATE3_FRAMES (default 9600, 96 kHz).
- R4: In any cycle without a frame strobe, hb_pull_low keeps its level, however many such cycles pass. The output never runs free of the frame strobes.
- R5: While run_en is 0, frame strobes are ignored, hb_pull_low holds and the frame count is kept at zero. After run_en returns to 1, a full phase of N strobes is needed before the next toggle.
- R6: If rate_sel changes to a phase length that the current count has already reached or passed, the next accepted strobe toggles the output and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe, one per audio frame (LR clock edge) |
| rate_sel | input | 2 | Sample-rate selection, sets the phase length |
| run_en | input | 1 | Allows the heartbeat to advance when 1 |
| hb_pull_low | output | 1 | Drive-low enable for the open-drain heartbeat pin |

## Verification
Every result of this block appears in the clock edge that samples the causing input: a completing strobe flips hb_pull_low at that edge, and a cycle with no strobe or with run_en low leaves it unchanged at that edge. The driver applies inputs on the falling edge and puts the level the requirements predict for that cycle into a queue. The monitor takes one entry out of the queue 2 ns after each rising edge, so each comparison falls in the cycle its cause was sampled. Reset is checked at a falling edge after the reset edges, once the queue has emptied. The bench uses short phase lengths so that rate changes, idle gaps and run gating all fall within a short run.

// File: rtl/hb_pkg.sv
// Package hb_pkg
// Shared rate encoding and width helpers for the frame-paced heartbeat.
// Assumes rate_sel is a two-bit code whose values are the enum below.
package hb_pkg;

    typedef enum logic [1:0] {
        RATE_48K  = 2'd0,
        RATE_44K1 = 2'd1,
        RATE_32K  = 2'd2,
        RATE_96K  = 2'd3
    } rate_e;

    // Largest of four phase lengths, used to size the frame counter.
    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/hb_term_sel.sv
// Module hb_term_sel
// Maps the rate code to the number of frames in one heartbeat phase.
// Assumes every phase length parameter is at least 1 and fits in CW bits.
module hb_term_sel #(
    parameter int unsigned RATE0_FRAMES = 4800,
    parameter int unsigned RATE1_FRAMES = 4410,
    parameter int unsigned RATE2_FRAMES = 3200,
    parameter int unsigned RATE3_FRAMES = 9600,
    parameter int unsigned CW           = 14
) (
    input  logic [1:0]    rate_sel,
    output logic [CW-1:0] term
);
    import hb_pkg::*;

    rate_e rate;
    assign rate = rate_e'(rate_sel);

    // Select the phase length for the current rate code.
    always_comb begin
        unique case (rate)
            RATE_48K:  term = CW'(RATE0_FRAMES);
            RATE_44K1: term = CW'(RATE1_FRAMES);
            RATE_32K:  term = CW'(RATE2_FRAMES);
            default:   term = CW'(RATE3_FRAMES);
        endcase
    end

endmodule

// File: rtl/hb_frame_cnt.sv
// Module hb_frame_cnt
// Counts accepted frame strobes and flags the strobe that completes a phase.
// Assumes term >= 1. A count at or beyond term-1 wraps on the next strobe,
// so a shorter term selected mid-phase cannot leave the counter stuck.
module hb_frame_cnt #(
    parameter int unsigned CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          frame_tick,
    input  logic [CW-1:0] term,
    output logic          wrap
);
    logic [CW-1:0] count;
    logic [CW:0]   next_count;

    assign next_count = {1'b0, count} + (CW+1)'(1);

    // Phase completes when this accepted strobe reaches the phase length.
    assign wrap = run_en && frame_tick && (next_count >= {1'b0, term});

    // Frame counter: cleared by reset or gating, restarted on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            count <= '0;
        end else if (frame_tick) begin
            if (wrap) count <= '0;
            else      count <= next_count[CW-1:0];
        end
    end

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));                                          // R2
    AST_GATED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (count == '0));                                       // R5
    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !frame_tick) |=> $stable(count));                      // R4

endmodule

// File: rtl/hb_level.sv
// Module hb_level
// Holds the heartbeat level and inverts it on each completed phase.
// Assumes wrap is a single-cycle pulse from the frame counter.
module hb_level (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    output logic level
);
    // Level register: released at reset, inverted once per phase.
    always_ff @(posedge clk) begin
        if (!rst_n)    level <= 1'b0;
        else if (wrap) level <= ~level;
    end

    AST_TOGGLE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (level != $past(level)));                                // R2

endmodule

// File: rtl/frame_heartbeat.sv
// Module frame_heartbeat
// Top of the frame-paced heartbeat: counts audio frame strobes and inverts
// an open-drain drive-low enable every phase of N frames (N from rate_sel).
// Assumes frame_tick is already synchronous to clk and one cycle wide.
module frame_heartbeat #(
    parameter int unsigned RATE0_FRAMES = 4800,
    parameter int unsigned RATE1_FRAMES = 4410,
    parameter int unsigned RATE2_FRAMES = 3200,
    parameter int unsigned RATE3_FRAMES = 9600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    input  logic [1:0] rate_sel,
    input  logic       run_en,
    output logic       hb_pull_low
);
    localparam int unsigned MAX_FRAMES =
        hb_pkg::max_of4(RATE0_FRAMES, RATE1_FRAMES, RATE2_FRAMES, RATE3_FRAMES);
    localparam int unsigned CW = $clog2(MAX_FRAMES + 1);

    logic [CW-1:0] term;
    logic          wrap;
    logic          level;

    hb_term_sel #(
        .RATE0_FRAMES(RATE0_FRAMES),
        .RATE1_FRAMES(RATE1_FRAMES),
        .RATE2_FRAMES(RATE2_FRAMES),
        .RATE3_FRAMES(RATE3_FRAMES),
        .CW(CW)
    ) u_term (
        .rate_sel(rate_sel),
        .term(term)
    );

    hb_frame_cnt #(.CW(CW)) u_cnt (
        .clk(clk),
        .rst_n(rst_n),
        .run_en(run_en),
        .frame_tick(frame_tick),
        .term(term),
        .wrap(wrap)
    );

    hb_level u_lvl (
        .clk(clk),
        .rst_n(rst_n),
        .wrap(wrap),
        .level(level)
    );

    // Pad control: a high level means pull the line low.
    assign hb_pull_low = level;

    AST_RESET_RELEASE: assert property (@(posedge clk)
        !rst_n |=> !hb_pull_low);                                         // R1
    AST_NO_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(hb_pull_low));                            // R4
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(hb_pull_low));                                // R5

endmodule

// File: tb/sim_frame_heartbeat.sv
// Scoreboard bench: the driver queues the expected level for each cycle it
// drives; the monitor takes one entry 2 ns after each rising edge.
module sim_frame_heartbeat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       run_en = 1'b0;
    logic       hb_pull_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    q_exp[$];
    string q_tag[$];

    // Bench model state, taken from the requirements.
    int m_cnt = 0;
    bit m_lvl = 1'b0;

    always #5 clk = ~clk;

    frame_heartbeat #(
        .RATE0_FRAMES(8),
        .RATE1_FRAMES(7),
        .RATE2_FRAMES(5),
        .RATE3_FRAMES(12)
    ) u0 (
        .clk(clk),
        .rst_n(rst_n),
        .frame_tick(frame_tick),
        .rate_sel(rate_sel),
        .run_en(run_en),
        .hb_pull_low(hb_pull_low)
    );

    function automatic int phase_len(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 7;
            2'd2: return 5;
            default: return 12;
        endcase
    endfunction

    // Driver: apply one cycle of inputs and queue the predicted level.
    task automatic step(input bit t, input bit run, input logic [1:0] sel, input string tag);
        @(negedge clk);
        frame_tick = t;
        run_en     = run;
        rate_sel   = sel;
        if (!run) begin
            m_cnt = 0;
        end else if (t) begin
            if (m_cnt + 1 >= phase_len(sel)) begin
                m_cnt = 0;
                m_lvl = ~m_lvl;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        q_exp.push_back(m_lvl);
        q_tag.push_back(tag);
    endtask

    // Apply reset, then check the released pin (R1).
    task automatic do_reset();
        @(negedge clk);
        frame_tick = 1'b0;
        wait (q_exp.size() == 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (hb_pull_low !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: hb_pull_low=%b expected=0", hb_pull_low);
        end
        rst_n = 1'b1;
        m_cnt = 0;
        m_lvl = 1'b0;
    endtask

    // Monitor: compare the output with the queued prediction.
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            bit    e;
            string tg;
            e  = q_exp.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (hb_pull_low !== e) begin
                fails++;
                $display("FAIL %s: hb_pull_low=%b expected=%b", tg, hb_pull_low, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();                                       // R1
        // R2 / R3: back-to-back strobes at rate 0 (8 frames per phase)
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 2'd0, "R2 rate0 dense");
        // R4: sparse strobes with idle gaps
        for (int i = 0; i < 45; i++) step(i % 3 == 0, 1'b1, 2'd0, "R4 sparse");
        // R4: long idle stretch, no free-running
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1, 2'd0, "R4 idle hold");
        // R3: each remaining rate code
        do_reset();
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 2'd1, "R3 rate1");
        do_reset();
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 2'd2, "R3 rate2");
        do_reset();
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 2'd3, "R3 rate3");
        // R5: partial phase, then gate with strobes present
        for (int i = 0; i < 4; i++)  step(1'b1, 1'b1, 2'd0, "R5 pre-gate");
        for (int i = 0; i < 25; i++) step(1'b1, 1'b0, 2'd0, "R5 gated");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 2'd0, "R5 restart full phase");
        // R6: long rate, partial count, then shorten the phase
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 2'd3, "R6 count up");
        step(1'b0, 1'b1, 2'd2, "R6 switch no strobe");
        step(1'b1, 1'b1, 2'd2, "R6 overrun wraps");
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 2'd2, "R6 after wrap");
        // R1: reset in the middle of a driven phase
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'd2, "R1 pre-reset");
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 2'd2, "R1 post-reset phase");
        step(1'b0, 1'b1, 2'd2, "R4 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule